// File: doc/BRIEF.md
# Reloading Countdown Timer with Two-Output Interrupt Routing

This block combines a self-reloading 12-bit down-counter with an interrupt router that feeds two active-low request lines: a normal request (`irq_n`) and a fast request (`firq_n`). Six event sources share both lines: the timer expiry, plus five pulse inputs for horizontal border, vertical border, serial input, keyboard and cartridge. Each line has its own six-bit enable mask and its own master enable. An event is latched into a line's pending flags only when that line's mask bit for the source is set. The line is driven low while its master enable is on and any of its flags is pending.

The timer decrements on a selectable tick. The choice is either a fast system strobe or a once-per-scanline strobe. A write to the timer high byte loads the full 12-bit value and starts counting. When the count runs out, the timer posts its event, reloads the programmed value and keeps going. Five byte registers behind a simple write/read strobe interface give software control of the block. A read of a mask register returns the pending flags and clears the event flags. The timer flag is the exception: software clears it by writing its mask bit to zero and then back to one.

Top module: `tick_irq_router`

## Requirements
- R1: In the cycle after synchronous reset is released, `irq_n` and `firq_n` are 1. All registers and pending flags are 0, `rd_data` is 0 and the timer is stopped.
- R2: Register map on `addr`: 0 = control, 1 = normal-line mask, 2 = fast-line mask, 3 = timer high byte, 4 = timer low byte. A write to address 3 loads the count {wr_data[3:0], timer low byte} and starts the timer if that value is nonzero. A loaded value of zero stops the timer.
- R3: The timer counts one per selected tick. On a tick that finds the count at 1, it raises the timer event, reloads {high nibble, low byte} and keeps running. A value of N gives one event every N ticks. A reload value of zero stops the timer. A high-byte load in the same cycle as a tick takes priority and raises no event.
- R4: Control bit 2 picks the tick. 0 selects `fast_tick` and 1 selects `line_tick`. The strobe that is not selected has no effect on the count.
- R5: Both mask registers use the same bit layout: bit5 timer, bit4 horizontal border, bit3 vertical border, bit2 serial input, bit1 keyboard, bit0 cartridge. An event sets a line's flag only if that line's mask bit is set. The two lines latch independently.
- R6: Control bit 0 is the normal-line master enable and control bit 1 is the fast-line master enable. One cycle after the flags and master are sampled, the line equals NOT(master AND any flag pending).
- R7: A read of address 1 or 2 returns {2'b00, flags} and clears that line's bits 4..0. An event arriving in the same cycle as the read stays latched.
- R8: A pending timer flag (bit5) survives reads. It is cleared only by writing its mask bit to 0.
- R9: Writing a mask bit to 0 clears that flag at once. An event in the same cycle as a mask write is judged against the newly written mask.
- R10: `rd_data` updates one cycle after `rd_en` and holds otherwise. Address 0 reads {5'b0, ctrl[2:0]}, address 3 reads {4'b0, high nibble}, address 4 reads the low byte, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| fast_tick | input | 1 | Fast system tick strobe |
| line_tick | input | 1 | Once-per-scanline tick strobe |
| ev_hbord | input | 1 | Horizontal border event pulse |
| ev_vbord | input | 1 | Vertical border event pulse |
| ev_serial | input | 1 | Serial input event pulse |
| ev_key | input | 1 | Keyboard event pulse |
| ev_cart | input | 1 | Cartridge event pulse |
| irq_n | output | 1 | Normal interrupt request, active low |
| firq_n | output | 1 | Fast interrupt request, active low |

## Verification
Two functions can land on the same edge: a read that clears the pending flags, and a fresh source event. The bench provokes this by pulsing the horizontal-border input in exactly the cycle that the fast-line mask register is read. The request line must stay low afterwards and a second read must still show the bit. A related collision is also covered: a high-byte load coinciding with a tick must restart the count without posting an event. The behavioural model in the bench predicts the outcome of each collision independently, and every clock compares both lines and the read data against it.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int SRC_N     = 6;
  localparam int TMR_BIT   = 5;
  localparam int LINE_N    = 2;
  localparam int AD_CTRL   = 0;
  localparam int AD_MASK0  = 1;
  localparam int AD_TMR_HI = 3;
  localparam int AD_TMR_LO = 4;
  localparam int CTRL_W    = 3;
  localparam int CTRL_TSEL = 2;
endpackage

// File: rtl/tick_irq_timer.sv
module tick_irq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  output logic             expire,
  output logic [CNT_W-1:0] cnt,
  output logic             run
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_one;

  assign at_one = (cnt_q == CNT_W'(1));
  assign expire = run_q & tick & ~load & at_one;
  assign cnt    = cnt_q;
  assign run    = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= |load_val;
    end else if (run_q && tick) begin
      if (at_one) begin
        cnt_q <= reload_val;
        run_q <= |reload_val;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tick_irq_flags.sv
module tick_irq_flags #(
  parameter int SRC_N  = 6,
  parameter int STICKY = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] en_next,
  input  logic [SRC_N-1:0] events,
  input  logic             rd_clr,
  output logic [SRC_N-1:0] flags
);
  localparam logic [SRC_N-1:0] KEEP = SRC_N'(1) << STICKY;
  logic [SRC_N-1:0] flags_q;
  logic [SRC_N-1:0] survive;

  assign survive = rd_clr ? (flags_q & KEEP) : flags_q;
  assign flags   = flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (survive | events) & en_next;
  end
endmodule

// File: rtl/tick_irq_router.sv
module tick_irq_router #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fast_tick,
  input  logic              line_tick,
  input  logic              ev_hbord,
  input  logic              ev_vbord,
  input  logic              ev_serial,
  input  logic              ev_key,
  input  logic              ev_cart,
  output logic              irq_n,
  output logic              firq_n
);
  import tick_irq_pkg::*;
  localparam int HI_W = CNT_W - DATA_W;

  logic [CTRL_W-1:0]            ctrl_q;
  logic [HI_W-1:0]              hi_q;
  logic [DATA_W-1:0]            lo_q;
  logic [LINE_N-1:0][SRC_N-1:0] en_q, en_next, flags;
  logic [LINE_N-1:0]            int_n_q;
  logic [SRC_N-1:0]             events;
  logic [DATA_W-1:0]            rd_val;
  logic                         tmr_load, tmr_tick, tmr_ev, tmr_run;
  logic [CNT_W-1:0]             tmr_cnt;

  assign tmr_load = wr_en && (addr == ADDR_W'(AD_TMR_HI));
  assign tmr_tick = ctrl_q[CTRL_TSEL] ? line_tick : fast_tick;

  tick_irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load       (tmr_load),
    .load_val   ({wr_data[HI_W-1:0], lo_q}),
    .reload_val ({hi_q, lo_q}),
    .tick       (tmr_tick),
    .expire     (tmr_ev),
    .cnt        (tmr_cnt),
    .run        (tmr_run)
  );

  assign events = {tmr_ev, ev_hbord, ev_vbord, ev_serial, ev_key, ev_cart};

  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    logic hit_mask;
    assign hit_mask   = (addr == ADDR_W'(AD_MASK0 + g));
    assign en_next[g] = (wr_en && hit_mask) ? wr_data[SRC_N-1:0] : en_q[g];

    tick_irq_flags #(.SRC_N(SRC_N), .STICKY(TMR_BIT)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .en_next (en_next[g]),
      .events  (events),
      .rd_clr  (rd_en && hit_mask),
      .flags   (flags[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]    <= '0;
        int_n_q[g] <= 1'b1;
      end else begin
        en_q[g]    <= en_next[g];
        int_n_q[g] <= ~(ctrl_q[g] & (|flags[g]));
      end
    end
  end

  assign irq_n  = int_n_q[0];
  assign firq_n = int_n_q[1];

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(AD_CTRL))        rd_val = DATA_W'(ctrl_q);
    else if (addr == ADDR_W'(AD_MASK0))  rd_val = DATA_W'(flags[0]);
    else if (addr == ADDR_W'(AD_MASK0 + 1)) rd_val = DATA_W'(flags[1]);
    else if (addr == ADDR_W'(AD_TMR_HI)) rd_val = DATA_W'(hi_q);
    else if (addr == ADDR_W'(AD_TMR_LO)) rd_val = lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(AD_CTRL))   ctrl_q <= wr_data[CTRL_W-1:0];
      if (tmr_load)                            hi_q   <= wr_data[HI_W-1:0];
      if (wr_en && addr == ADDR_W'(AD_TMR_LO)) lo_q   <= wr_data;
      if (rd_en)                               rd_data <= rd_val;
    end
  end
endmodule

// File: rtl/tick_irq_router_chk.sv
module tick_irq_router_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              irq_n,
  input logic              firq_n,
  input logic [2:0]        ctrl,
  input logic [5:0]        irq_en,
  input logic [5:0]        irq_flags,
  input logic [5:0]        firq_flags,
  input logic [CNT_W-1:0]  cnt,
  input logic              run
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_n && firq_n));

  a_r6_irq_asserts: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && (irq_flags != 6'd0)) |=> !irq_n);

  a_r6_firq_masked: assert property (@(posedge clk) disable iff (rst)
    !ctrl[1] |=> firq_n);

  a_r5_flag_within_mask: assert property (@(posedge clk) disable iff (rst)
    (irq_flags & ~irq_en) == 6'd0);

  a_r8_timer_flag_held: assert property (@(posedge clk) disable iff (rst)
    (irq_flags[5] && !(wr_en && addr == ADDR_W'(1) && !wr_data[5])) |=> irq_flags[5]);

  a_r2_running_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
endmodule

bind tick_irq_router tick_irq_router_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .irq_n      (irq_n),
  .firq_n     (firq_n),
  .ctrl       (ctrl_q),
  .irq_en     (en_q[0]),
  .irq_flags  (flags[0]),
  .firq_flags (flags[1]),
  .cnt        (tmr_cnt),
  .run        (tmr_run)
);

// File: tb/tick_irq_router_test.sv
module tick_irq_router_test;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic fast_tick = 0, line_tick = 0;
  logic ev_hbord = 0, ev_vbord = 0, ev_serial = 0, ev_key = 0, ev_cart = 0;
  logic irq_n, firq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_irq_router uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0] m_ctrl;
  logic [5:0] m_ien, m_fen, m_ifl, m_ffl;
  logic [3:0] m_hi;
  logic [7:0] m_lo, m_rd;
  int m_cnt;
  bit m_run, m_irq_n, m_firq_n;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_ien = 0; m_fen = 0; m_ifl = 0; m_ffl = 0;
      m_hi = 0; m_lo = 0; m_rd = 0; m_cnt = 0; m_run = 0;
      m_irq_n = 1; m_firq_n = 1;
    end else begin
      bit tk, ld, tev, ni, nf;
      logic [5:0] evs, nien, nfen, ikeep, fkeep;
      tk  = m_ctrl[2] ? line_tick : fast_tick;
      ld  = wr_en && addr == 3;
      tev = !ld && m_run && tk && m_cnt == 1;
      evs = {tev, ev_hbord, ev_vbord, ev_serial, ev_key, ev_cart};
      if (rd_en)
        case (addr)
          0: m_rd = {5'd0, m_ctrl};
          1: m_rd = {2'd0, m_ifl};
          2: m_rd = {2'd0, m_ffl};
          3: m_rd = {4'd0, m_hi};
          4: m_rd = m_lo;
          default: m_rd = 0;
        endcase
      ni = !(m_ctrl[0] && m_ifl != 0);
      nf = !(m_ctrl[1] && m_ffl != 0);
      nien = (wr_en && addr == 1) ? wr_data[5:0] : m_ien;
      nfen = (wr_en && addr == 2) ? wr_data[5:0] : m_fen;
      ikeep = (rd_en && addr == 1) ? (m_ifl & 6'h20) : m_ifl;
      fkeep = (rd_en && addr == 2) ? (m_ffl & 6'h20) : m_ffl;
      m_ifl = (ikeep | evs) & nien;
      m_ffl = (fkeep | evs) & nfen;
      if (ld) begin
        m_cnt = {wr_data[3:0], m_lo};
        m_run = m_cnt != 0;
      end else if (m_run && tk) begin
        if (m_cnt == 1) begin
          m_cnt = {m_hi, m_lo};
          m_run = m_cnt != 0;
        end else m_cnt = m_cnt - 1;
      end
      if (ld) m_hi = wr_data[3:0];
      if (wr_en && addr == 4) m_lo = wr_data;
      if (wr_en && addr == 0) m_ctrl = wr_data[2:0];
      m_ien = nien; m_fen = nfen;
      m_irq_n = ni; m_firq_n = nf;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq_n === m_irq_n, "R6 irq_n vs model", irq_n, m_irq_n);
      check(firq_n === m_firq_n, "R6 firq_n vs model", firq_n, m_firq_n);
      check(rd_data === m_rd, "R10 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a);
    rd_en = 1; addr = 3'(a);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3); rst = 0; idle(1);
    check(irq_n === 1 && firq_n === 1, "R1 lines idle after reset", {irq_n, firq_n}, 3);
    check(rd_data === 0, "R1 rd_data after reset", rd_data, 0);

    // timer, fast tick every cycle, period 3
    wr(0, 3); wr(1, 8'h20); wr(4, 3);
    fast_tick = 1;
    wr(3, 0);
    idle(1);
    check(irq_n === 1, "R2 no event before count runs out", irq_n, 1);
    idle(4);
    check(irq_n === 0, "R3 timer expiry asserts irq_n", irq_n, 0);
    rd(1); idle(1);
    check(rd_data === 8'h20, "R7 read shows timer flag", rd_data, 8'h20);
    rd(1); idle(1);
    check(rd_data === 8'h20 && irq_n === 0, "R8 timer flag survives read", rd_data, 8'h20);
    wr(1, 0); idle(2);
    check(irq_n === 1, "R8 mask clear drops timer flag", irq_n, 1);
    check(firq_n === 1, "R5 fast line untouched by timer", firq_n, 1);

    // load coinciding with tick, then stop with zero
    wr(1, 8'h20); wr(4, 0); wr(3, 0);
    wr(1, 0); wr(1, 8'h20); idle(20);
    check(irq_n === 1, "R2 zero load stops timer", irq_n, 1);

    // tick select: scanline tick, fast tick ignored
    wr(4, 2); wr(0, 8'h07); wr(3, 0); idle(20);
    check(irq_n === 1, "R4 unselected fast_tick ignored", irq_n, 1);
    line_tick = 1; idle(1); line_tick = 0; idle(2);
    check(irq_n === 1, "R4 one line tick not enough", irq_n, 1);
    line_tick = 1; idle(1); line_tick = 0; idle(2);
    check(irq_n === 0, "R3 two line ticks expire period 2", irq_n, 0);
    wr(1, 0); wr(4, 0); wr(3, 0); idle(2);

    // sources routed per line
    wr(1, 8'h01); wr(2, 8'h10);
    ev_hbord = 1; idle(1); ev_hbord = 0; idle(2);
    check(firq_n === 0 && irq_n === 1, "R5 hbord only to fast line", {irq_n, firq_n}, 2);
    ev_cart = 1; idle(1); ev_cart = 0; idle(2);
    check(irq_n === 0, "R5 cart to normal line", irq_n, 0);
    rd(2); idle(2);
    check(rd_data === 8'h10 && firq_n === 1, "R7 read clears hbord flag", rd_data, 8'h10);

    // collision: event in the same cycle as the clearing read
    ev_hbord = 1; rd(2); ev_hbord = 0; idle(2);
    check(firq_n === 0, "R7 coincident event survives read", firq_n, 0);
    rd(2); idle(1);
    check(rd_data === 8'h10, "R7 flag still visible", rd_data, 8'h10);
    // event together with mask write judged against new mask
    ev_key = 1; wr(1, 8'h02); ev_key = 0; idle(1);
    check(irq_n === 0, "R9 key event with same-cycle mask set", irq_n, 0);
    wr(1, 8'h00); idle(2);
    check(irq_n === 1, "R9 mask clear drops flags", irq_n, 1);

    // master enable
    ev_hbord = 1; idle(1); ev_hbord = 0; idle(2);
    wr(0, 8'h01); idle(2);
    check(firq_n === 1, "R6 master off masks fast line", firq_n, 1);
    wr(0, 8'h03); idle(2);
    check(firq_n === 0, "R6 master on shows pending flag", firq_n, 0);

    // readback
    wr(4, 8'hA5); wr(3, 8'hF9);
    rd(4); idle(1);
    check(rd_data === 8'hA5, "R10 low byte readback", rd_data, 8'hA5);
    rd(3); idle(1);
    check(rd_data === 8'h09, "R10 high nibble readback", rd_data, 8'h09);
    rd(0); idle(3);
    check(rd_data === 8'h03, "R10 control readback held", rd_data, 8'h03);
    rd(6); idle(1);
    check(rd_data === 8'h00, "R10 unused address reads zero", rd_data, 0);
    idle(30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule